// File: doc/BRIEF.md
# Dual-Bank Cascading Interrupt Router

This block collects a set of level-sensitive peripheral interrupt lines and routes them to several processor cores, with one output group per core. Each core owns a private register bank: an enable mask, a live status view of the inputs, and a set of routing registers. The routing registers assign each input a small field that selects which of the core's parent interrupt lines it raises. Because every bank is a full copy, software on one core can enable, disable or re-route a source for that core without changing what any other core sees.

Software reaches the banks through a simple word-addressed register port. The upper address bits select the bank (core index) and the lower bits select the word inside it. Every output line is registered, so a change on an input or in a register shows up at the outputs on the clock edge after it is sampled.

Top module: `mcic_top`

## Requirements
- R1: While reset is held, and after it is released, every mask bit and every routing field in every bank is 0 and every output line is low.
- R2: Word offset 0 of a bank is its mask register. Bit n enables input n for that core, and the written value reads back unchanged.
- R3: Word offset 1 of a bank reads the present level of every input (bit n = input n). A write to offset 1 changes no register.
- R4: Offsets 2 to 5 hold the routing registers 0 to 3. The 4-bit field of input n sits in routing register 3 − n/8 (integer division), starting at bit 4·(n mod 8). So register 3 serves inputs 0–7 and register 0 serves inputs 24–31, and a written value reads back unchanged.
- R5: An input whose routing field is 0 raises no output line, whatever its mask and level.
- R6: Output line k (k = 1..N_LINES) of core c, at bit c·N_LINES + k − 1 of `irq_o`, is high when at least one input is high, enabled in core c's mask, and has routing value k in core c's bank. Value 1 selects that core's default line, bit c·N_LINES.
- R7: A routing value above N_LINES (5 to 15 with the defaults) raises no output line.
- R8: A write to one bank leaves the mask and routing registers of every other bank unchanged.
- R9: The outputs are registered. A change on `irq_i` or in a register does not reach `irq_o` before the next rising clock edge, and it reaches it on that edge.
- R10: A write to an offset above 5, or to a bank index of N_CORE or more, changes nothing. A read there returns 0.
- R11: A read returns its data on `bus_rdata_o` in the cycle after the request. In a cycle that follows no read request, `bus_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_i | input | N_SRC (32) | Level-sensitive interrupt inputs |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | BANK_AW+OFF_W (5) | Word address {bank, offset} |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| irq_o | output | N_CORE·N_LINES (8) | Per-core parent interrupt lines, core c at bits c·N_LINES upward |

## Verification
The hardest situation to reach is two banks holding different routing for the same source while that source is live, with the field placed in the reversed register order. The outputs must then tell the cores apart, and must not show any mix-up of register index or bit position. The stimulus writes fields for inputs at both ends of the range (1 and 31) and into the same source on both cores with different line numbers. It then runs a long random mix of mask writes, routing writes, input changes and readbacks. A bench-side model of the requirements predicts every output vector and every routing word.

// File: rtl/mcic_pkg.sv
package mcic_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned OFF_MASK   = 0;
   localparam int unsigned OFF_STAT   = 1;
   localparam int unsigned OFF_ROUTE0 = 2;

   // routing register index that holds the field of a source (reversed order)
   function automatic int unsigned route_reg(int unsigned src, int unsigned per_reg,
                                             int unsigned n_regs);
      return n_regs - 1 - (src / per_reg);
   endfunction

   // lowest bit of the field of a source inside its routing register
   function automatic int unsigned route_lsb(int unsigned src, int unsigned fw,
                                             int unsigned per_reg);
      return fw * (src % per_reg);
   endfunction
endpackage

// File: rtl/mcic_bank.sv
module mcic_bank
   import mcic_pkg::*;
#(
   parameter int unsigned N_SRC   = 32,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned OFF_W   = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en_i,
   input  logic [OFF_W-1:0]           off_i,
   input  logic [REG_W-1:0]           wdata_i,
   input  logic [N_SRC-1:0]           level_i,
   output logic [N_SRC-1:0]           mask_o,
   output logic [N_SRC*FIELD_W-1:0]   route_o,
   output logic [REG_W-1:0]           rdata_o
);
   localparam int unsigned SPR    = REG_W / FIELD_W;
   localparam int unsigned N_RREG = N_SRC / SPR;

   logic [N_SRC-1:0]        mask_q;
   logic [N_RREG*REG_W-1:0] view_flat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_en_i && off_i == OFF_W'(OFF_MASK)) begin
         mask_q <= wdata_i[N_SRC-1:0];
      end
   end

   assign mask_o = mask_q;

   for (genvar n = 0; n < N_SRC; n++) begin : g_field
      localparam int unsigned RI  = route_reg(n, SPR, N_RREG);
      localparam int unsigned LSB = route_lsb(n, FIELD_W, SPR);
      logic [FIELD_W-1:0] fld_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fld_q <= '0;
         end else if (wr_en_i && off_i == OFF_W'(OFF_ROUTE0 + RI)) begin
            fld_q <= wdata_i[LSB +: FIELD_W];
         end
      end

      assign route_o[n*FIELD_W +: FIELD_W]          = fld_q;
      assign view_flat[RI*REG_W + LSB +: FIELD_W]   = fld_q;
   end

   always_comb begin
      rdata_o = '0;
      if (off_i == OFF_W'(OFF_MASK)) begin
         rdata_o[N_SRC-1:0] = mask_q;
      end else if (off_i == OFF_W'(OFF_STAT)) begin
         rdata_o[N_SRC-1:0] = level_i;
      end else begin
         for (int r = 0; r < int'(N_RREG); r++) begin
            if (off_i == OFF_W'(OFF_ROUTE0 + r)) begin
               rdata_o = view_flat[r*REG_W +: REG_W];
            end
         end
      end
   end
endmodule

// File: rtl/mcic_router.sv
module mcic_router #(
   parameter int unsigned N_SRC   = 32,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned N_LINES = 4
) (
   input  logic [N_SRC-1:0]         pend_i,
   input  logic [N_SRC*FIELD_W-1:0] route_i,
   output logic [N_LINES-1:0]       lines_o
);
   // line k is driven by routing value k; 0 and values above N_LINES match nothing
   for (genvar k = 1; k <= N_LINES; k++) begin : g_line
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int n = 0; n < int'(N_SRC); n++) begin
            if (pend_i[n] && route_i[n*FIELD_W +: FIELD_W] == FIELD_W'(k)) begin
               hit = 1'b1;
            end
         end
      end
      assign lines_o[k-1] = hit;
   end
endmodule

// File: rtl/mcic_top.sv
module mcic_top
   import mcic_pkg::*;
#(
   parameter int unsigned N_CORE  = 2,
   parameter int unsigned N_SRC   = 32,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned N_LINES = 4,
   parameter int unsigned BANK_AW = 2,
   localparam int unsigned SPR    = REG_W / FIELD_W,
   localparam int unsigned N_RREG = N_SRC / SPR,
   localparam int unsigned OFF_W  = $clog2(OFF_ROUTE0 + N_RREG),
   localparam int unsigned ADDR_W = BANK_AW + OFF_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_SRC-1:0]           irq_i,
   input  logic                       bus_req_i,
   input  logic                       bus_we_i,
   input  logic [ADDR_W-1:0]          bus_addr_i,
   input  logic [REG_W-1:0]           bus_wdata_i,
   output logic [REG_W-1:0]           bus_rdata_o,
   output logic [N_CORE*N_LINES-1:0]  irq_o
);
   if (REG_W % FIELD_W != 0) begin : g_bad_field
      $error("FIELD_W must divide the register width");
   end
   if (N_SRC > REG_W || N_SRC % SPR != 0) begin : g_bad_src
      $error("N_SRC must be a multiple of fields per register and fit one register");
   end
   if (N_LINES < 1 || N_LINES >= (1 << FIELD_W)) begin : g_bad_lines
      $error("N_LINES must be 1 .. 2**FIELD_W-1");
   end
   if (N_CORE < 1 || N_CORE > (1 << BANK_AW)) begin : g_bad_core
      $error("N_CORE must fit the bank address field");
   end

   logic [BANK_AW-1:0]             bank_idx;
   logic [OFF_W-1:0]               off_idx;
   logic [N_CORE*REG_W-1:0]        bank_rdata;
   logic [N_CORE*N_SRC-1:0]        mask_all;
   logic [N_CORE*N_SRC*FIELD_W-1:0] route_all;
   logic [REG_W-1:0]               rd_sel;
   logic [REG_W-1:0]               rdata_q;

   assign bank_idx = bus_addr_i[ADDR_W-1:OFF_W];
   assign off_idx  = bus_addr_i[OFF_W-1:0];

   for (genvar c = 0; c < N_CORE; c++) begin : g_core
      logic                       wr_en;
      logic [N_SRC-1:0]           mask_c;
      logic [N_SRC*FIELD_W-1:0]   route_c;
      logic [N_LINES-1:0]         lines_c;
      logic [N_LINES-1:0]         out_q;

      assign wr_en = bus_req_i && bus_we_i && (bank_idx == BANK_AW'(c));

      mcic_bank #(
         .N_SRC   (N_SRC),
         .FIELD_W (FIELD_W),
         .OFF_W   (OFF_W)
      ) i_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en_i (wr_en),
         .off_i   (off_idx),
         .wdata_i (bus_wdata_i),
         .level_i (irq_i),
         .mask_o  (mask_c),
         .route_o (route_c),
         .rdata_o (bank_rdata[c*REG_W +: REG_W])
      );

      mcic_router #(
         .N_SRC   (N_SRC),
         .FIELD_W (FIELD_W),
         .N_LINES (N_LINES)
      ) i_router (
         .pend_i  (irq_i & mask_c),
         .route_i (route_c),
         .lines_o (lines_c)
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_q <= '0;
         end else begin
            out_q <= lines_c;
         end
      end

      assign irq_o[c*N_LINES +: N_LINES]               = out_q;
      assign mask_all[c*N_SRC +: N_SRC]                = mask_c;
      assign route_all[c*N_SRC*FIELD_W +: N_SRC*FIELD_W] = route_c;
   end

   always_comb begin
      rd_sel = '0;
      for (int c = 0; c < int'(N_CORE); c++) begin
         if (bank_idx == BANK_AW'(c)) begin
            rd_sel = bank_rdata[c*REG_W +: REG_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_req_i && !bus_we_i) begin
         rdata_q <= rd_sel;
      end else begin
         rdata_q <= '0;
      end
   end

   assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/mcic_chk.sv
module mcic_chk #(
   parameter int unsigned N_CORE  = 2,
   parameter int unsigned N_SRC   = 32,
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned N_LINES = 4,
   parameter int unsigned BANK_AW = 2,
   parameter int unsigned N_RREG  = 4,
   parameter int unsigned OFF_W   = 3,
   parameter int unsigned ADDR_W  = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [N_SRC-1:0]            irq_i,
   input logic                        bus_req_i,
   input logic                        bus_we_i,
   input logic [ADDR_W-1:0]           bus_addr_i,
   input logic [N_CORE*N_LINES-1:0]   irq_o,
   input logic [N_CORE*N_SRC-1:0]     mask_all,
   input logic [N_CORE*N_SRC*FIELD_W-1:0] route_all
);
   logic [BANK_AW-1:0] a_bank;
   logic [OFF_W-1:0]   a_off;
   logic               a_wr;

   assign a_bank = bus_addr_i[ADDR_W-1:OFF_W];
   assign a_off  = bus_addr_i[OFF_W-1:0];
   assign a_wr   = bus_req_i && bus_we_i;

   // R1: reset clears state and outputs
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (irq_o == '0 && mask_all == '0 && route_all == '0));

   // R3: status offset is read-only
   a_r3_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && a_off == OFF_W'(1)) |=> ($stable(mask_all) && $stable(route_all)));

   // R10: unmapped offsets and banks are ignored
   a_r10_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && (int'(a_off) >= 2 + int'(N_RREG) || int'(a_bank) >= int'(N_CORE)))
      |=> ($stable(mask_all) && $stable(route_all)));

   for (genvar c = 0; c < N_CORE; c++) begin : g_chk
      // R8: banks are independent
      a_r8_other_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
         (a_wr && a_bank != BANK_AW'(c))
         |=> ($stable(mask_all[c*N_SRC +: N_SRC]) &&
              $stable(route_all[c*N_SRC*FIELD_W +: N_SRC*FIELD_W])));

      // R6: no pending input for a core leaves its lines low on the next edge
      a_r6_idle_core_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (~|(irq_i & mask_all[c*N_SRC +: N_SRC])) |=> (irq_o[c*N_LINES +: N_LINES] == '0));
   end
endmodule

bind mcic_top mcic_chk #(
   .N_CORE  (N_CORE),
   .N_SRC   (N_SRC),
   .FIELD_W (FIELD_W),
   .N_LINES (N_LINES),
   .BANK_AW (BANK_AW),
   .N_RREG  (N_RREG),
   .OFF_W   (OFF_W),
   .ADDR_W  (ADDR_W)
) u_mcic_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_i      (irq_i),
   .bus_req_i  (bus_req_i),
   .bus_we_i   (bus_we_i),
   .bus_addr_i (bus_addr_i),
   .irq_o      (irq_o),
   .mask_all   (mask_all),
   .route_all  (route_all)
);

// File: tb/test_mcic_top.sv
`timescale 1ns/1ps
module test_mcic_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  irq_out;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   typedef struct {
      int          due;
      bit          is_out;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t q[$];

   logic [31:0] mmask [2];
   int          mroute [2][32];

   always #5 clk = ~clk;
   always @(posedge clk) cyc++;

   mcic_top i_mcic_top (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_i       (irq_in),
      .bus_req_i   (req),
      .bus_we_i    (we),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq_out)
   );

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares queued expectations when they fall due
   always @(posedge clk) begin
      #2;
      while (q.size() > 0 && q[0].due <= cyc) begin
         item_t it;
         logic [31:0] act;
         it  = q.pop_front();
         act = it.is_out ? {24'b0, irq_out} : rdata;
         check(act === it.exp && it.due == cyc, it.tag, act, it.exp);
      end
   end

   function automatic logic [7:0] model_out();
      logic [7:0] v = '0;
      for (int c = 0; c < 2; c++)
         for (int n = 0; n < 32; n++)
            if (irq_in[n] && mmask[c][n] && mroute[c][n] >= 1 && mroute[c][n] <= 4)
               v[c*4 + mroute[c][n] - 1] = 1'b1;
      return v;
   endfunction

   function automatic logic [31:0] model_irr(int c, int r);
      logic [31:0] v = '0;
      for (int j = 0; j < 8; j++) v[4*j +: 4] = 4'(mroute[c][(3-r)*8 + j]);
      return v;
   endfunction

   task automatic bus_wr(int c, int off, logic [31:0] d);
      req = 1'b1; we = 1'b1; addr = {2'(c), 3'(off)}; wdata = d;
      if (c < 2 && off == 0) mmask[c] = d;
      if (c < 2 && off >= 2 && off <= 5)
         for (int j = 0; j < 8; j++) mroute[c][(3-(off-2))*8 + j] = int'(d[4*j +: 4]);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic bus_rd(int c, int off, logic [31:0] exp, string tag);
      item_t it;
      req = 1'b1; we = 1'b0; addr = {2'(c), 3'(off)};
      it.due = cyc + 1; it.is_out = 1'b0; it.exp = exp; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic chk_out(string tag);
      item_t it;
      it.due = cyc + 1; it.is_out = 1'b1; it.exp = {24'b0, model_out()}; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
   endtask

   task automatic chk_idle_rd(string tag);
      item_t it;
      it.due = cyc + 1; it.is_out = 1'b0; it.exp = '0; it.tag = tag;
      q.push_back(it);
      @(negedge clk);
   endtask

   initial begin
      #(1_000_000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 2; c++) begin
         mmask[c] = '0;
         for (int n = 0; n < 32; n++) mroute[c][n] = 0;
      end
      repeat (3) @(negedge clk);
      // R1: outputs low during reset
      #1 check(irq_out === 8'h00, "R1 outputs in reset", {24'b0, irq_out}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: cleared state after reset
      bus_rd(0, 0, 32'h0, "R1 mask core0");
      bus_rd(1, 0, 32'h0, "R1 mask core1");
      for (int r = 0; r < 4; r++) bus_rd(1, 2 + r, 32'h0, "R1 routing core1");
      irq_in = 32'hFFFF_FFFF;
      chk_out("R1 no output after reset");
      irq_in = '0;

      // R2 / R8: mask readback, other bank untouched
      bus_wr(0, 0, 32'hA5A5_0F0F);
      bus_rd(0, 0, 32'hA5A5_0F0F, "R2 mask readback");
      bus_rd(1, 0, 32'h0, "R8 other bank mask");

      // R3: status mirrors inputs, write ignored
      irq_in = 32'h1234_8001;
      bus_rd(0, 1, 32'h1234_8001, "R3 status core0");
      bus_rd(1, 1, 32'h1234_8001, "R3 status core1");
      bus_wr(0, 1, 32'hFFFF_FFFF);
      bus_rd(0, 0, 32'hA5A5_0F0F, "R3 status write leaves mask");
      irq_in = 32'h0000_00F0;
      bus_rd(0, 1, 32'h0000_00F0, "R3 status follows input");
      irq_in = '0;

      // R4: field placement, reversed register order
      bus_wr(0, 0, 32'h8000_0002);
      bus_wr(0, 5, 32'h0000_0010);   // register 3: input 1 -> value 1
      bus_wr(0, 2, 32'h1000_0000);   // register 0: input 31 -> value 1
      bus_rd(0, 5, 32'h0000_0010, "R4 routing reg3 readback");
      bus_rd(0, 2, 32'h1000_0000, "R4 routing reg0 readback");
      irq_in = 32'h0000_0002;
      chk_out("R4 input1 on default line");
      irq_in = 32'h8000_0000;
      chk_out("R4 input31 on default line");

      // R6: default line and higher lines
      bus_wr(0, 2, 32'h3000_0000);   // input 31 -> line 3
      chk_out("R6 input31 on line 3");
      bus_wr(0, 2, 32'h4000_0000);   // input 31 -> line 4
      chk_out("R6 input31 on line 4");

      // R7: unused values disconnect
      bus_wr(0, 2, 32'h5000_0000);
      chk_out("R7 value 5 disconnected");
      bus_wr(0, 2, 32'hF000_0000);
      chk_out("R7 value 15 disconnected");

      // R5: value 0 disconnects
      bus_wr(0, 2, 32'h0000_0000);
      irq_in = 32'h8000_0002;
      bus_wr(0, 5, 32'h0000_0000);
      chk_out("R5 value 0 disconnected");

      // R8: banks diverge for the same source
      bus_wr(0, 5, 32'h0000_0010);
      bus_wr(1, 0, 32'h0000_0002);
      bus_wr(1, 5, 32'h0000_0020);   // core1 input1 -> line 2
      irq_in = 32'h0000_0002;
      chk_out("R8 both cores different lines");
      bus_rd(0, 5, 32'h0000_0010, "R8 core0 routing unchanged");

      // R9: registered output
      begin
         logic [7:0] prev;
         prev = model_out();
         irq_in = '0;
         #1 check(irq_out === prev, "R9 no combinational path", {24'b0, irq_out}, {24'b0, prev});
         chk_out("R9 update on next edge");
      end

      // R10: unmapped offsets and banks
      bus_wr(2, 0, 32'hFFFF_FFFF);
      bus_wr(0, 6, 32'hFFFF_FFFF);
      bus_wr(3, 5, 32'hFFFF_FFFF);
      bus_rd(0, 0, 32'h8000_0002, "R10 mask unchanged");
      bus_rd(1, 5, 32'h0000_0020, "R10 routing unchanged");
      bus_rd(2, 0, 32'h0, "R10 absent bank reads 0");
      bus_rd(3, 1, 32'h0, "R10 absent bank status reads 0");
      bus_rd(0, 7, 32'h0, "R10 unmapped offset reads 0");

      // R11: read data only after a read
      bus_rd(0, 0, 32'h8000_0002, "R11 read data next cycle");
      chk_idle_rd("R11 idle read data zero");

      // random mix against the model
      for (int i = 0; i < 300; i++) begin
         int op = $urandom_range(0, 3);
         int c  = $urandom_range(0, 1);
         int r  = $urandom_range(0, 3);
         case (op)
            0: bus_wr(c, 0, $urandom());
            1: bus_wr(c, 2 + r, $urandom());
            2: irq_in = $urandom();
            default: bus_rd(c, 2 + r, model_irr(c, r), "R4 random routing readback");
         endcase
         chk_out("R6 random routing");
      end

      repeat (3) @(negedge clk);
      check(q.size() == 0, "scoreboard drained", q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule